// File: doc/BRIEF.md
# Prescaled Dual-Channel Pulse-Width Modulator

This block produces pulse-width modulated outputs from a single clock. A power-of-two clock divider, selected by a 3-bit field, produces a count enable. That enable advances one shared period counter, which wraps at a programmable modulo value. Every channel compares the shared count against its own duty value. Each channel also has a polarity bit that selects whether the active level is high or low. All channels therefore run at the same period, while their pulse widths differ.

Software programs the block through a simple write port that carries an address and data. New modulo and duty values go into holding registers first. They are copied into the working registers only when the counter wraps, so a reprogramming in mid-period never produces a shortened or stretched pulse. Two values bypass the usual compare and act as fixed rules: a duty of zero keeps the output idle, and a duty at or above the modulo keeps it constantly active. With a 16 MHz clock, a divider of 16, a modulo of 20000 and a duty between 1000 and 2000, the output is a 50 Hz servo signal with 1 µs steps.

Top module: `pwm_pair`

## Requirements
- R1: Bits [2:0] of the control word (address 0) select a divide ratio of 2^value. The period counter advances once every 2^value clocks, so the ratio is one of 1, 2, 4, 8, 16, 32, 64 or 128.
- R2: The modulo word (address 1) sets the period. The counter runs from 0 to modulo−1, so one output period lasts modulo × divide-ratio clocks.
- R3: The duty words are at address 2 for channel 0 and address 3 for channel 1. For 0 < duty < modulo, a channel is active while the count is below its duty, which gives duty × divide-ratio active clocks in each period.
- R4: A duty of zero holds the channel at its idle level for the whole period.
- R5: A duty greater than or equal to the modulo holds the channel at its active level continuously.
- R6: Control bit 3 is the polarity of channel 0 and bit 4 is the polarity of channel 1. A polarity of 0 gives a high pulse with a low idle level. A polarity of 1 gives a low pulse with a high idle level.
- R7: Both channels share one divider and one counter. They have the same period and independent duty values.
- R8: Writes to the modulo or duty registers take effect only at the next wrap of the counter. A pulse already in progress keeps its old width.
- R9: Reset is asynchronous and active low. It clears the counter and all registers, and it drives every output to the low idle level. That level stays until the block is reprogrammed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(N_CH+2) (2) | Register address: 0 control, 1 modulo, 2+n duty of channel n |
| wr_data | input | CNT_W (16) | Write data |
| pwm_o | output | N_CH (2) | PWM outputs, one bit per channel |

## Verification
A counter that overruns or wraps early changes the number of clocks between rising edges. That error shows up in the edge count of a measurement window within one period. A divider that taps the wrong bit scales both the period and the active time by a power of two, which is just as quick to see. If the holding registers are copied to the working set outside the wrap, the pulse in progress has the wrong width. That pulse is the one right after the write, so the error appears within a single period. A wrong polarity or a wrong reset value is visible on the next clock edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // register map of the write port
   localparam int unsigned REG_CTRL      = 0;
   localparam int unsigned REG_MOD       = 1;
   localparam int unsigned REG_DUTY_BASE = 2;

   // low-bit mask whose all-ones pattern marks a divider tap
   function automatic logic [31:0] tap_mask(input int unsigned sel);
      return (32'd1 << sel) - 32'd1;
   endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] mask;

   always_comb mask = DIV_W'(pwm_pkg::tap_mask(32'(ps)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_cnt <= '0;
      else        div_cnt <= div_cnt + DIV_W'(1);
   end

   assign tick = ((div_cnt & mask) == mask);
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] mod_act,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic last;

   always_comb last = (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, mod_act});
   assign wrap = tick & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= last ? '0 : cnt + CNT_W'(1);
   end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile #(
   parameter int CNT_W  = 16,
   parameter int PS_W   = 3,
   parameter int N_CH   = 2,
   parameter int ADDR_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [CNT_W-1:0]           wr_data,
   input  logic                       load,
   output logic [PS_W-1:0]            ps,
   output logic [N_CH-1:0]            pol,
   output logic [CNT_W-1:0]           mod_act,
   output logic [N_CH-1:0][CNT_W-1:0] duty_act
);
   import pwm_pkg::*;

   logic [CNT_W-1:0] mod_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps      <= '0;
         pol     <= '0;
         mod_sh  <= '0;
         mod_act <= '0;
      end else begin
         if (wr_en && wr_addr == ADDR_W'(REG_CTRL)) begin
            ps  <= wr_data[PS_W-1:0];
            pol <= wr_data[PS_W +: N_CH];
         end
         if (wr_en && wr_addr == ADDR_W'(REG_MOD)) mod_sh <= wr_data;
         if (load) mod_act <= mod_sh;
      end
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_duty
      logic [CNT_W-1:0] duty_sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            duty_sh     <= '0;
            duty_act[c] <= '0;
         end else begin
            if (wr_en && wr_addr == ADDR_W'(REG_DUTY_BASE + c)) duty_sh <= wr_data;
            if (load) duty_act[c] <= duty_sh;
         end
      end
   end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] mod_act,
   input  logic [CNT_W-1:0] duty,
   input  logic             pol,
   output logic             pwm
);
   logic active;

   always_comb begin
      if (duty == '0)            active = 1'b0;
      else if (duty >= mod_act)  active = 1'b1;
      else                       active = (cnt < duty);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm <= 1'b0;
      else        pwm <= active ^ pol;
   end
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
   parameter int  CNT_W  = 16,
   parameter int  PS_W   = 3,
   parameter int  N_CH   = 2,
   localparam int ADDR_W = $clog2(N_CH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [N_CH-1:0]   pwm_o
);
   if (PS_W < 1 || PS_W > 5) begin : g_bad_ps
      $error("pwm_pair: PS_W must lie in 1..5");
   end
   if (N_CH < 1 || PS_W + N_CH > CNT_W) begin : g_bad_ch
      $error("pwm_pair: control word cannot hold divider and polarity bits");
   end

   logic                       tick;
   logic                       wrap;
   logic [PS_W-1:0]            ps;
   logic [N_CH-1:0]            pol;
   logic [CNT_W-1:0]           cnt;
   logic [CNT_W-1:0]           mod_act;
   logic [N_CH-1:0][CNT_W-1:0] duty_act;

   pwm_prescale #(.PS_W(PS_W)) presc_i (
      .clk(clk), .rst_n(rst_n), .ps(ps), .tick(tick)
   );

   pwm_period_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mod_act(mod_act),
      .cnt(cnt), .wrap(wrap)
   );

   pwm_regfile #(.CNT_W(CNT_W), .PS_W(PS_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load(wrap), .ps(ps), .pol(pol),
      .mod_act(mod_act), .duty_act(duty_act)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      pwm_compare #(.CNT_W(CNT_W)) cmp_i (
         .clk(clk), .rst_n(rst_n), .cnt(cnt), .mod_act(mod_act),
         .duty(duty_act[c]), .pol(pol[c]), .pwm(pwm_o[c])
      );
   end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
   parameter int CNT_W = 16,
   parameter int N_CH  = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [N_CH-1:0]            pwm_o,
   input logic [N_CH-1:0]            pol,
   input logic [CNT_W-1:0]           cnt,
   input logic                       wrap,
   input logic [CNT_W-1:0]           mod_act,
   input logic [N_CH-1:0][CNT_W-1:0] duty_act
);
   // R9
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> pwm_o == '0);

   // R2
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_act != '0) |-> (cnt < mod_act));

   // R8
   mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(mod_act));

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      // R8
      duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wrap |=> $stable(duty_act[c]));

      // R4
      zero_duty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (duty_act[c] == '0) |=> (pwm_o[c] == $past(pol[c])));

      // R5
      full_duty_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (duty_act[c] != '0 && duty_act[c] >= mod_act) |=> (pwm_o[c] == !$past(pol[c])));
   end
endmodule

bind pwm_pair pwm_pair_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) chk_i (
   .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .pol(pol), .cnt(cnt),
   .wrap(wrap), .mod_act(mod_act), .duty_act(duty_act)
);

// File: tb/pwm_pair_tb_top.sv
module pwm_pair_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  pwm_o;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_pair dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 2'(addr);
      wr_data = 16'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // ctrl = ps | pol0<<3 | pol1<<4
   task automatic cfg(input int ps, input int pols, input int md, input int d0, input int d1);
      wr(0, ps | (pols << 3));
      wr(1, md);
      wr(2, d0);
      wr(3, d1);
      repeat (SETTLE) @(negedge clk);
   endtask

   // high samples and level changes of one channel over len cycles
   task automatic measure(input int ch, input int len, output int hi, output int tog);
      logic prev;
      hi = 0;
      tog = 0;
      @(negedge clk);
      prev = pwm_o[ch];
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (pwm_o[ch]) hi++;
         if (pwm_o[ch] != prev) tog++;
         prev = pwm_o[ch];
      end
   endtask

   task automatic t_reset();
      int hi, tog;
      repeat (4) @(negedge clk);
      check("R9", "ch0 during reset", int'(pwm_o[0]), 0);
      check("R9", "ch1 during reset", int'(pwm_o[1]), 0);
      rst_n = 1'b1;
      measure(0, 20, hi, tog);
      check("R9", "ch0 high after reset", hi, 0);
      measure(1, 20, hi, tog);
      check("R9", "ch1 high after reset", hi, 0);
   endtask

   task automatic t_basic();
      int hi, tog;
      cfg(0, 0, 10, 3, 7);
      measure(0, 50, hi, tog);
      check("R3", "ch0 high in 5 periods", hi, 15);
      check("R2", "ch0 edges in 5 periods", tog, 10);
      measure(1, 50, hi, tog);
      check("R7", "ch1 high in 5 periods", hi, 35);
      check("R7", "ch1 edges in 5 periods", tog, 10);
   endtask

   task automatic t_prescale();
      int hi, tog;
      cfg(2, 0, 5, 2, 0);
      measure(0, 100, hi, tog);
      check("R1", "div4 high", hi, 40);
      check("R1", "div4 edges", tog, 10);
      cfg(7, 0, 3, 1, 0);
      measure(0, 768, hi, tog);
      check("R1", "div128 high", hi, 256);
      check("R1", "div128 edges", tog, 4);
   endtask

   task automatic t_zero();
      int hi, tog;
      cfg(0, 0, 10, 0, 5);
      measure(0, 40, hi, tog);
      check("R4", "zero duty pol0 high", hi, 0);
      cfg(0, 1, 10, 0, 5);
      measure(0, 40, hi, tog);
      check("R4", "zero duty pol1 high", hi, 40);
   endtask

   task automatic t_full();
      int hi, tog;
      cfg(0, 0, 10, 10, 5);
      measure(0, 40, hi, tog);
      check("R5", "duty==mod high", hi, 40);
      check("R5", "duty==mod edges", tog, 0);
      cfg(0, 0, 10, 200, 5);
      measure(0, 40, hi, tog);
      check("R5", "duty>mod high", hi, 40);
      cfg(0, 1, 10, 200, 5);
      measure(0, 40, hi, tog);
      check("R5", "duty>mod pol1 high", hi, 0);
   endtask

   task automatic t_pol();
      int hi, tog;
      cfg(0, 1, 10, 3, 7);
      measure(0, 50, hi, tog);
      check("R6", "ch0 inverted high", hi, 35);
      check("R6", "ch0 inverted edges", tog, 10);
      measure(1, 50, hi, tog);
      check("R6", "ch1 normal high", hi, 35);
   endtask

   task automatic wait_rise();
      logic prev;
      @(negedge clk);
      prev = pwm_o[0];
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (pwm_o[0] && !prev) break;
         prev = pwm_o[0];
      end
   endtask

   task automatic t_latch();
      int len;
      cfg(0, 0, 10, 3, 0);
      wait_rise();
      len = 1;
      fork
         wr(2, 8);
      join_none
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (pwm_o[0]) len++;
         else break;
      end
      check("R8", "pulse in progress width", len, 3);
      wait_rise();
      len = 1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (pwm_o[0]) len++;
         else break;
      end
      check("R8", "next pulse width", len, 8);
   endtask

   task automatic t_reset_midrun();
      int hi, tog;
      cfg(0, 2, 10, 10, 0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R9", "ch0 in mid-run reset", int'(pwm_o[0]), 0);
      check("R9", "ch1 in mid-run reset", int'(pwm_o[1]), 0);
      rst_n = 1'b1;
      measure(0, 30, hi, tog);
      check("R9", "ch0 idle after mid-run reset", hi, 0);
      measure(1, 30, hi, tog);
      check("R9", "ch1 idle after mid-run reset", hi, 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_prescale();
      t_zero();
      t_full();
      t_pol();
      t_latch();
      t_reset_midrun();
      summary();
      $finish;
   end
endmodule